// File: doc/BRIEF.md
# Predicated Packed-Lane Add/Subtract Execute Stage

This block is the execute stage for within-register SIMD on a 32-bit integer register file. It takes a decoded vector-op instruction word with the values read for the first, second and third source registers. It also takes the old contents of the destination register, the value of register 1 and a global saturation mode bit. One cycle later it returns a write-back value, a write enable and the destination number. The supported operations are lane-wise add and subtract, with an optional third operand that is added in, an optional immediate as the second operand, and signed saturation.

The lane layout comes from the destination register number. Registers 0 to 15 hold four 8-bit lanes, registers 16 to 29 hold two 16-bit lanes, and registers 30 and 31 hold one signed 32-bit value. A 2-bit per-instruction field chooses among three behaviours: no mask with the global saturation setting, no mask with forced saturation, or a per-lane mask taken from register 1 or from its complement. Strided and indexed vector memory encodings raise a trap so that software can emulate them.

Top module: `psimd_exec`

## Requirements
- R1: The major opcode 7'h57 sits in bits 6:0. Bit 14 = 1 selects the three-operand form, lane = rs3 + (rs1 ± rs2). Bit 14 = 0 with bit 25 = 0 selects lane = rs1 ± rs2. Bit 14 = 0 with bit 25 = 1 selects lane = rs1 ± imm, where the signed 8-bit imm has imm[7:5] = bits 28:26 and imm[4:0] = bits 24:20, sign-extended to the lane width.
- R2: Function codes are read from bits 31:26 in the register form, from bits 31:29 in the immediate form, and from bits 26:25 in the three-operand form. In each form, function bit 0 selects subtract and function bit 1 selects saturation. In the register form a value above 3 is illegal, and in the immediate form a set bit 2 is illegal. An illegal function raises trap and gives no write enable.
- R3: The lane width comes from rd (bits 11:7). Registers 0–15 use four 8-bit lanes, registers 16–29 use two 16-bit lanes, and registers 30–31 use one 32-bit lane. All source operands are sliced with the destination's layout.
- R4: When saturation is not active, each lane result wraps modulo 2^width.
- R5: When saturation is active, each lane result is clamped to the signed minimum or maximum of the lane. Saturation is active if function bit 1 is set, or if mm (bits 13:12) = 01, or if mm is 00, 10 or 11 and the global saturation input is 1.
- R6: With mm = 10, lane i is written only if bit i of v1 is 1. A lane whose bit is 0 keeps the corresponding bits of the old rd value.
- R7: With mm = 11, lane i is written only if bit i of v1 is 0. With mm = 00 or 01, every lane is written.
- R8: A legal vector op whose rd is 0 produces out_valid without wb_en.
- R9: Outputs are registered. out_valid is 1 exactly in the cycle after in_valid was sampled high. wb_rd then equals that instruction's rd, and wb_en is 1 for a legal vector op with a nonzero rd.
- R10: Opcode 7'h07 (vector load) or 7'h27 (vector store) with bits 27:26 not equal to 00 (strided or indexed) raises trap without wb_en. A unit-stride access (00), or any other opcode, raises neither trap nor wb_en.
- R11: While reset is asserted, and in the first cycle after it is released, out_valid, wb_en and trap are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are valid |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | First source value |
| rs2_val | input | 32 | Second source value |
| rs3_val | input | 32 | Third source value |
| rd_old | input | 32 | Current destination contents |
| v1_val | input | 32 | Register 1 value, used as mask source |
| sat_glb | input | 1 | Global saturation mode |
| out_valid | output | 1 | Result strobe |
| wb_en | output | 1 | Register write enable |
| wb_rd | output | 5 | Destination register number |
| wb_data | output | 32 | Write-back value |
| trap | output | 1 | Illegal-instruction trap |

## Verification
A wrong lane-width choice corrupts wb_data on the very next out_valid: carries cross 8-bit boundaries, or 16-bit clamps appear where 8-bit clamps were expected. A wrong mask polarity or a wrong mask bit index shows up at once as lanes taking rd_old where they should take results, or the reverse. Stale pipeline state shows up as out_valid, wb_en or trap in a cycle that follows no valid input. Because the block holds only a single stage of state, every fault appears within one cycle of the instruction that exposes it.

// File: rtl/psimd_pkg.sv
package psimd_pkg;
  localparam logic [6:0] OPC_VOP   = 7'h57;
  localparam logic [6:0] OPC_VLOAD = 7'h07;
  localparam logic [6:0] OPC_VSTOR = 7'h27;

  typedef enum logic [1:0] {LS8 = 2'd0, LS16 = 2'd1, LS32 = 2'd2} lsize_e;

  typedef enum logic [1:0] {
    MM_GLOBAL = 2'b00,
    MM_FORCE  = 2'b01,
    MM_V1     = 2'b10,
    MM_NV1    = 2'b11
  } mmode_e;

  typedef struct packed {
    logic       is_vop;
    logic       legal;
    logic       trap;
    logic       sub;
    logic       sat_op;
    logic       use_imm;
    logic       acc3;
    mmode_e     mm;
    logic [4:0] rd;
    logic [7:0] imm;
  } dec_t;
endpackage

// File: rtl/psimd_decode.sv
module psimd_decode
  import psimd_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic [6:0] opc;
  logic       three, immf, is_mem, bad_fn;

  always_comb begin
    opc    = instr[6:0];
    three  = instr[14];
    immf   = !instr[14] && instr[25];
    is_mem = (opc == OPC_VLOAD) || (opc == OPC_VSTOR);
    if (three)     bad_fn = 1'b0;
    else if (immf) bad_fn = instr[31];
    else           bad_fn = |instr[31:28];

    dec.is_vop  = (opc == OPC_VOP);
    dec.legal   = !bad_fn;
    dec.trap    = (dec.is_vop && bad_fn) || (is_mem && (instr[27:26] != 2'b00));
    dec.use_imm = immf;
    dec.acc3    = three;
    if (three) begin
      dec.sub    = instr[25];
      dec.sat_op = instr[26];
    end else begin
      dec.sub    = immf ? instr[29] : instr[26];
      dec.sat_op = immf ? instr[30] : instr[27];
    end
    dec.mm  = mmode_e'(instr[13:12]);
    dec.rd  = instr[11:7];
    dec.imm = {instr[28:26], instr[24:20]};
  end
endmodule

// File: rtl/psimd_lane_alu.sv
module psimd_lane_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic         sub,
  input  logic         sat,
  output logic [W-1:0] y
);
  localparam logic signed [W+1:0] MAXV = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [W+1:0] MINV = {3'b111, {(W-1){1'b0}}};

  logic signed [W+1:0] ea, eb, ec, sum;

  always_comb begin
    ea  = {{2{a[W-1]}}, a};
    eb  = {{2{b[W-1]}}, b};
    ec  = {{2{c[W-1]}}, c};
    sum = sub ? (ea - eb + ec) : (ea + eb + ec);
    if (sat && (sum > MAXV))      y = MAXV[W-1:0];
    else if (sat && (sum < MINV)) y = MINV[W-1:0];
    else                          y = sum[W-1:0];
  end
endmodule

// File: rtl/psimd_exec.sv
module psimd_exec
  import psimd_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int NARROW_HI = 16,
  parameter int WIDE_BASE = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] rs3_val,
  input  logic [XLEN-1:0] rd_old,
  input  logic [XLEN-1:0] v1_val,
  input  logic            sat_glb,
  output logic            out_valid,
  output logic            wb_en,
  output logic [4:0]      wb_rd,
  output logic [XLEN-1:0] wb_data,
  output logic            trap
);
  localparam int NBYTE = XLEN / 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dec_t dec;
  psimd_decode u_dec (.instr(instr), .dec(dec));

  lsize_e          lsz;
  logic            sat_eff;
  logic [NBYTE-1:0] mask, be;
  logic [XLEN-1:0] res8, res16, res32, res_sel, merged;

  always_comb begin
    if (dec.rd < 5'(NARROW_HI))      lsz = LS8;
    else if (dec.rd >= 5'(WIDE_BASE)) lsz = LS32;
    else                              lsz = LS16;
    sat_eff = dec.sat_op || (dec.mm == MM_FORCE) || sat_glb;
    case (dec.mm)
      MM_V1:   mask = v1_val[NBYTE-1:0];
      MM_NV1:  mask = ~v1_val[NBYTE-1:0];
      default: mask = '1;
    endcase
  end

  // one lane group per width; the destination layout picks one
  for (genvar g = 0; g < 3; g++) begin : g_width
    localparam int W = 8 << g;
    localparam int N = XLEN / W;
    logic [XLEN-1:0] res;
    for (genvar i = 0; i < N; i++) begin : g_lane
      logic [W-1:0] bop, cop;
      assign bop = dec.use_imm ? {{(W-8){dec.imm[7]}}, dec.imm} : rs2_val[i*W +: W];
      assign cop = dec.acc3 ? rs3_val[i*W +: W] : '0;
      psimd_lane_alu #(.W(W)) u_alu (
        .a  (rs1_val[i*W +: W]),
        .b  (bop),
        .c  (cop),
        .sub(dec.sub),
        .sat(sat_eff),
        .y  (res[i*W +: W])
      );
    end
  end
  assign res8  = g_width[0].res;
  assign res16 = g_width[1].res;
  assign res32 = g_width[2].res;

  always_comb begin
    case (lsz)
      LS8:     res_sel = res8;
      LS16:    res_sel = res16;
      default: res_sel = res32;
    endcase
    for (int j = 0; j < NBYTE; j++) begin
      case (lsz)
        LS8:     be[j] = mask[j];
        LS16:    be[j] = mask[j/2];
        default: be[j] = mask[0];
      endcase
      merged[j*8 +: 8] = be[j] ? res_sel[j*8 +: 8] : rd_old[j*8 +: 8];
    end
  end

  // next state
  logic            vld_d, en_d, trap_d;
  logic [4:0]      rd_d;
  logic [XLEN-1:0] data_d;
  always_comb begin
    vld_d  = in_valid;
    en_d   = in_valid && dec.is_vop && dec.legal && (dec.rd != 5'd0);
    trap_d = in_valid && dec.trap;
    rd_d   = in_valid ? dec.rd : wb_rd;
    data_d = in_valid ? merged : wb_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      trap      <= 1'b0;
      wb_rd     <= '0;
      wb_data   <= '0;
    end else begin
      out_valid <= vld_d;
      wb_en     <= en_d;
      trap      <= trap_d;
      wb_rd     <= rd_d;
      wb_data   <= data_d;
    end
  end
endmodule

// File: rtl/psimd_exec_chk.sv
module psimd_exec_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] rd_old,
  input logic [XLEN-1:0] v1_val,
  input logic            out_valid,
  input logic            wb_en,
  input logic            trap
);
  logic seen_clk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_clk <= 1'b0;
    else        seen_clk <= 1'b1;
  end

  // R9
  valid_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_clk)
    out_valid == $past(in_valid));

  // R9
  no_output_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wb_en && !trap));

  // R10
  trap_excludes_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap && wb_en));

  // R8
  rd_zero_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[11:7] == 5'd0) |=> !wb_en);

  // R6
  empty_mask_keeps_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[6:0] == 7'h57 && instr[13:12] == 2'b10 && v1_val == '0)
      |=> (out_valid && psimd_exec.wb_data == $past(rd_old)));
endmodule

bind psimd_exec psimd_exec_chk #(.XLEN(XLEN)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
  .rd_old(rd_old), .v1_val(v1_val), .out_valid(out_valid),
  .wb_en(wb_en), .trap(trap)
);

// File: tb/test_psimd_exec.sv
`timescale 1ns/1ps
module test_psimd_exec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr, rs1_val, rs2_val, rs3_val, rd_old, v1_val;
  logic        sat_glb;
  logic        out_valid, wb_en, trap;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  psimd_exec i_psimd_exec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .rs3_val(rs3_val),
    .rd_old(rd_old), .v1_val(v1_val), .sat_glb(sat_glb),
    .out_valid(out_valid), .wb_en(wb_en), .wb_rd(wb_rd),
    .wb_data(wb_data), .trap(trap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint lane_s(input logic [31:0] v, input int i, input int w);
    longint x;
    x = longint'((v >> (i*w))) & ((longint'(1) << w) - 1);
    if (x >= (longint'(1) << (w-1))) x -= (longint'(1) << w);
    return x;
  endfunction

  // reference model built from the requirement text
  task automatic model(input logic [31:0] ins, a, b, c, old, v1, input logic sg,
                       output logic [31:0] res, output logic en, output logic tr);
    logic [6:0] opc;
    logic three, immf, legal, sub, sat;
    logic [5:0] fn;
    logic [4:0] rd;
    logic [1:0] mm;
    logic [31:0] mask;
    logic [7:0] imm;
    int w, n;
    opc = ins[6:0];
    res = 32'h0; en = 0; tr = 0;
    if (opc == 7'h07 || opc == 7'h27) begin
      tr = (ins[27:26] != 2'b00);
      return;
    end
    if (opc != 7'h57) return;
    three = ins[14];
    immf  = !three && ins[25];
    fn    = three ? {4'b0, ins[26:25]} : immf ? {3'b0, ins[31:29]} : ins[31:26];
    legal = (fn < 4);
    sub = fn[0]; rd = ins[11:7]; mm = ins[13:12];
    imm = {ins[28:26], ins[24:20]};
    sat = fn[1] || mm == 2'b01 || sg;
    mask = (mm == 2'b10) ? v1 : (mm == 2'b11) ? ~v1 : 32'hffff_ffff;
    w = (rd < 16) ? 8 : (rd < 30) ? 16 : 32;
    n = 32 / w;
    for (int i = 0; i < n; i++) begin
      longint x, y, z, s, mx, mn, lm;
      x = lane_s(a, i, w);
      y = immf ? longint'($signed(imm)) : lane_s(b, i, w);
      z = three ? lane_s(c, i, w) : 0;
      s = sub ? x - y + z : x + y + z;
      mx = (longint'(1) << (w-1)) - 1;
      mn = -(longint'(1) << (w-1));
      if (sat && s > mx) s = mx;
      if (sat && s < mn) s = mn;
      lm = (longint'(1) << w) - 1;
      for (int k = 0; k < w; k++)
        res[i*w + k] = mask[i] ? s[k] : old[i*w + k];
    end
    en = legal && rd != 0;
    tr = !legal;
  endtask

  task automatic run(input string req, input logic [31:0] ins, a, b, c, old, v1,
                     input logic sg);
    logic [31:0] er; logic ee, et;
    model(ins, a, b, c, old, v1, sg, er, ee, et);
    @(negedge clk);
    in_valid = 1; instr = ins; rs1_val = a; rs2_val = b; rs3_val = c;
    rd_old = old; v1_val = v1; sat_glb = sg;
    @(negedge clk);
    in_valid = 0;
    chk({req, " R9 valid"}, {31'b0, out_valid}, 32'd1);
    chk({req, " wb_en"}, {31'b0, wb_en}, {31'b0, ee});
    chk({req, " R10 trap"}, {31'b0, trap}, {31'b0, et});
    if (ee) begin
      chk({req, " data"}, wb_data, er);
      chk({req, " R9 rd"}, {27'b0, wb_rd}, {27'b0, ins[11:7]});
    end
  endtask

  function automatic logic [31:0] e_rr(input logic [5:0] f, input logic [1:0] mm, input logic [4:0] rd);
    return {f, 1'b0, 5'd2, 5'd3, 1'b0, mm, rd, 7'h57};
  endfunction
  function automatic logic [31:0] e_ri(input logic [2:0] f, input logic [7:0] im, input logic [1:0] mm, input logic [4:0] rd);
    return {f, im[7:5], 1'b1, im[4:0], 5'd3, 1'b0, mm, rd, 7'h57};
  endfunction
  function automatic logic [31:0] e_r3(input logic [1:0] f, input logic [1:0] mm, input logic [4:0] rd);
    return {5'd4, f, 5'd2, 5'd3, 1'b1, mm, rd, 7'h57};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; in_valid = 0; instr = 0; rs1_val = 0; rs2_val = 0; rs3_val = 0;
    rd_old = 0; v1_val = 0; sat_glb = 0;
    repeat (3) @(negedge clk);
    chk("R11 valid in reset", {31'b0, out_valid}, 32'd0);
    chk("R11 wb_en in reset", {31'b0, wb_en}, 32'd0);
    chk("R11 trap in reset", {31'b0, trap}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 valid after release", {31'b0, out_valid}, 32'd0);
    repeat (2) @(negedge clk);

    // R4 wrap, 8-bit lanes: 7f+01 -> 80
    run("R4 wrap8", e_rr(6'd0, 2'b00, 5'd5), 32'h7f01_ff7f, 32'h0101_0101, 0, 0, 0, 0);
    chk("R4 wrap8 value", wb_data, 32'h8002_0080);
    // R5 forced saturation via mm=01
    run("R5 force sat", e_rr(6'd0, 2'b01, 5'd5), 32'h7f01_807f, 32'h0101_ff01, 0, 0, 0, 0);
    chk("R5 clamp8", wb_data, 32'h7f02_807f);
    // R5 global saturation, 16-bit sub to minimum
    run("R5 glb sat16", e_rr(6'd1, 2'b00, 5'd20), 32'h8000_0005, 32'h0001_0003, 0, 0, 0, 1);
    chk("R5 clamp16", wb_data, 32'h8000_0002);
    // R2 saturating-function code, R3 32-bit lane on rd=30
    run("R2 satadd32", e_rr(6'd2, 2'b00, 5'd30), 32'h7fff_fff0, 32'h0000_0100, 0, 0, 0, 0);
    chk("R3 clamp32", wb_data, 32'h7fff_ffff);
    // R3 register 16 uses 16-bit lanes (carry crosses byte boundary)
    run("R3 lane16", e_rr(6'd0, 2'b00, 5'd16), 32'h00ff_00ff, 32'h0001_0001, 0, 0, 0, 0);
    chk("R3 carry16", wb_data, 32'h0100_0100);
    // R1 immediate form, negative imm
    run("R1 imm", e_ri(3'd0, 8'hfe, 2'b00, 5'd7), 32'h0000_0310, 0, 0, 0, 0, 0);
    chk("R1 imm value", wb_data, 32'hfefe_010e);
    // R1 three-operand form
    run("R1 acc3", e_r3(2'd1, 2'b00, 5'd18), 32'h0010_0020, 32'h0001_0002, 32'h0100_0200, 0, 0, 0);
    chk("R1 acc3 value", wb_data, 32'h010f_021e);
    // R6 mask by v1
    run("R6 mask v1", e_rr(6'd0, 2'b10, 5'd3), 32'h1111_1111, 32'h0101_0101, 0, 32'haaaa_aaaa, 32'h5, 0);
    chk("R6 lanes", wb_data, 32'haa12_aa12);
    // R7 complement mask, 16-bit
    run("R7 mask nv1", e_rr(6'd0, 2'b11, 5'd17), 32'h1000_2000, 32'h0001_0001, 0, 32'hbeef_cafe, 32'h1, 0);
    chk("R7 lanes", wb_data, 32'h1001_cafe);
    // R8 rd zero
    run("R8 rd0", e_rr(6'd0, 2'b00, 5'd0), 1, 1, 0, 0, 0, 0);
    chk("R8 no write", {31'b0, wb_en}, 32'd0);
    // R2 illegal functions
    run("R2 illegal rr", e_rr(6'd5, 2'b00, 5'd4), 1, 1, 0, 0, 0, 0);
    run("R2 illegal imm", e_ri(3'd4, 8'h01, 2'b00, 5'd4), 1, 1, 0, 0, 0, 0);
    // R10 memory encodings
    run("R10 strided", {4'h0, 2'b10, 19'h0, 7'h07}, 0, 0, 0, 0, 0, 0);
    run("R10 indexed", {4'h0, 2'b11, 19'h0, 7'h27}, 0, 0, 0, 0, 0, 0);
    run("R10 unit", {4'h0, 2'b00, 19'h0, 7'h07}, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R9 idle", {31'b0, out_valid}, 32'd0);

    for (int t = 0; t < 600; t++) begin
      logic [31:0] ins;
      int pick;
      ins  = $urandom;
      pick = $urandom_range(0, 9);
      if (pick < 7) begin
        ins[6:0] = 7'h57;
        if (!ins[14] && !ins[25] && $urandom_range(0, 3) != 0) ins[31:28] = 4'h0;
        if (!ins[14] && ins[25] && $urandom_range(0, 3) != 0) ins[31] = 1'b0;
      end else if (pick < 9) ins[6:0] = pick[0] ? 7'h07 : 7'h27;
      run("R1-rand", ins, $urandom, $urandom, $urandom, $urandom, $urandom, 1'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule